// File: doc/BRIEF.md
# Descending Stack Pointer Unit

This unit holds the stack pointer of a small processor core. The stack grows toward lower addresses. The control path raises one of four strobes: byte push, byte pop, return-address save (call or interrupt entry) and return-address restore (return or interrupt return). The unit then moves the pointer by the step that fits the operation: one for a byte and two for a return address. It also produces, one cycle later, the memory address and direction of the stack access. A push or a save writes at the current pointer and then moves down. A pop or a restore moves up first and reads there. The sequencer issues the second byte of a return address itself.

Software sees the pointer as two byte-wide registers, a low half and a high half, through a simple read/write strobe interface. Only the low `SP_BITS` bits are stored. The rest read as zero. A sticky flag reports when the pointer has been driven into the reserved region at or below the stack floor. Software clears the flag by writing either half of the pointer.

Top module: `sp_unit`

## Requirements
- R1: After a synchronous reset the pointer is 0x0000, the underflow flag is 0, the access-valid output is 0 and the read data is 0x00.
- R2: A byte push moves the pointer down by one. In the next cycle the access reports the old pointer as address, with the write direction (`acc_wr_o`=1).
- R3: A byte pop moves the pointer up by one. In the next cycle the access reports old pointer + 1 as address, with the read direction (`acc_wr_o`=0).
- R4: A return-address save moves the pointer down by two. The access reports the old pointer as address, with the write direction.
- R5: A return-address restore moves the pointer up by two. The access reports old pointer + 1 as address, with the read direction.
- R6: A register write with `io_hi_sel`=1 replaces pointer bits 15:8, and with `io_hi_sel`=0 replaces bits 7:0. The other half is kept. A read with `io_re` returns the selected half on `io_rdata` one cycle later.
- R7: A register write in the same cycle as any strobe wins. The strobe has no effect on the pointer and produces no access (`acc_vld_o` stays 0).
- R8: When several strobes are raised together, only one acts. The priority is save, then restore, then push, then pop.
- R9: Pointer bits at and above `SP_BITS` (default 11) are not stored. They read as zero both on `sp_o` and through the register interface.
- R10: A push or save whose result lands at or below `FLOOR` (default 0x60), or wraps below zero, sets the underflow flag. The pointer still moves. The flag stays set through later operations until a register write clears it.
- R11: Pointer arithmetic wraps modulo 2^`SP_BITS`. A pop at the top value gives 0, and a push at 0 gives the top value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_we | input | 1 | Register write strobe |
| io_re | input | 1 | Register read strobe |
| io_hi_sel | input | 1 | Selects the high half (1) or low half (0) |
| io_wdata | input | 8 | Register write data |
| io_rdata | output | 8 | Registered read data |
| push_i | input | 1 | Byte push strobe |
| pop_i | input | 1 | Byte pop strobe |
| call_i | input | 1 | Return-address save strobe |
| ret_i | input | 1 | Return-address restore strobe |
| sp_o | output | 16 | Current pointer, zero-extended |
| acc_vld_o | output | 1 | Stack access valid, one cycle after the strobe |
| acc_addr_o | output | 16 | Address of that access |
| acc_wr_o | output | 1 | 1 for a write access, 0 for a read access |
| uflow_o | output | 1 | Sticky underflow flag |

## Verification
The assertions check these rules on every cycle:
- each single-strobe step size in both directions, with wrap;
- the suppression of accesses by a register write;
- the holding and clearing of the underflow flag;
- the zero upper pointer bits;
- the reset state.

Other behaviour shows up only in the bench scenarios: the exact access addresses and directions, the strobe priority when strobes coincide, which byte half a write replaces, the read-back latency, and the exact floor boundary where the flag first sets.

// File: rtl/sp_unit_pkg.sv
package sp_unit_pkg;

  localparam int unsigned PTR_W  = 16;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_PUSH,
    OP_POP,
    OP_CALL,
    OP_RET
  } sp_op_e;

  function automatic logic op_moves_down(sp_op_e op);
    return (op == OP_PUSH) || (op == OP_CALL);
  endfunction

  function automatic logic [1:0] op_step(sp_op_e op);
    case (op)
      OP_PUSH, OP_POP: return 2'd1;
      OP_CALL, OP_RET: return 2'd2;
      default:         return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/sp_op_decode.sv
module sp_op_decode
  import sp_unit_pkg::*;
(
  input  logic       io_we,
  input  logic       push_i,
  input  logic       pop_i,
  input  logic       call_i,
  input  logic       ret_i,
  output sp_op_e     op_o,
  output logic [1:0] step_o,
  output logic       down_o
);

  // register write suppresses every strobe; among strobes save > restore > push > pop
  always_comb begin
    op_o = OP_NONE;
    if (!io_we) begin
      if (call_i)      op_o = OP_CALL;
      else if (ret_i)  op_o = OP_RET;
      else if (push_i) op_o = OP_PUSH;
      else if (pop_i)  op_o = OP_POP;
    end
  end

  assign step_o = op_step(op_o);
  assign down_o = op_moves_down(op_o);

endmodule

// File: rtl/sp_ptr_reg.sv
module sp_ptr_reg
  import sp_unit_pkg::*;
#(
  parameter int unsigned SP_BITS = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_we,
  input  logic              io_re,
  input  logic              io_hi_sel,
  input  logic [BYTE_W-1:0] io_wdata,
  input  sp_op_e            op_i,
  input  logic [1:0]        step_i,
  input  logic              down_i,
  output logic [PTR_W-1:0]  sp_o,
  output logic [BYTE_W-1:0] io_rdata
);

  logic [SP_BITS-1:0] sp_q;
  logic [SP_BITS-1:0] sp_d;
  logic [PTR_W-1:0]   sp_ext;
  logic [PTR_W-1:0]   wr_merge;
  logic [BYTE_W-1:0]  rd_q;

  // zero-extension of the implemented bits
  generate
    if (SP_BITS < PTR_W) begin : g_part
      assign sp_ext = {{(PTR_W-SP_BITS){1'b0}}, sp_q};
    end else begin : g_full
      assign sp_ext = sp_q;
    end
  endgenerate

  always_comb begin
    wr_merge = sp_ext;
    if (io_hi_sel) wr_merge[PTR_W-1:BYTE_W] = io_wdata;
    else           wr_merge[BYTE_W-1:0]     = io_wdata;
  end

  always_comb begin
    sp_d = sp_q;
    if (io_we)                sp_d = wr_merge[SP_BITS-1:0];
    else if (op_i != OP_NONE) begin
      if (down_i) sp_d = sp_q - SP_BITS'(step_i);
      else        sp_d = sp_q + SP_BITS'(step_i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q <= '0;
      rd_q <= '0;
    end else begin
      sp_q <= sp_d;
      if (io_re) rd_q <= io_hi_sel ? sp_ext[PTR_W-1:BYTE_W] : sp_ext[BYTE_W-1:0];
    end
  end

  assign sp_o     = sp_ext;
  assign io_rdata = rd_q;

endmodule

// File: rtl/sp_floor_guard.sv
module sp_floor_guard
  import sp_unit_pkg::*;
#(
  parameter int unsigned FLOOR = 16'h0060
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             io_we,
  input  logic             down_i,
  input  logic [1:0]       step_i,
  input  logic [PTR_W-1:0] sp_i,
  output logic             uflow_o
);

  localparam logic [PTR_W:0] FLOOR_X = (PTR_W+1)'(FLOOR);

  logic [PTR_W:0] limit;
  logic           hit;
  logic           flag_q;

  // new = sp - step lands at or below FLOOR (or wraps) <=> sp <= FLOOR + step
  assign limit = FLOOR_X + (PTR_W+1)'(step_i);
  assign hit   = down_i && ({1'b0, sp_i} <= limit);

  always_ff @(posedge clk) begin
    if (rst)        flag_q <= 1'b0;
    else if (io_we) flag_q <= 1'b0;
    else if (hit)   flag_q <= 1'b1;
  end

  assign uflow_o = flag_q;

endmodule

// File: rtl/sp_unit.sv
module sp_unit
  import sp_unit_pkg::*;
#(
  parameter int unsigned SP_BITS = 11,
  parameter int unsigned FLOOR   = 16'h0060
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        io_we,
  input  logic        io_re,
  input  logic        io_hi_sel,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  input  logic        push_i,
  input  logic        pop_i,
  input  logic        call_i,
  input  logic        ret_i,
  output logic [15:0] sp_o,
  output logic        acc_vld_o,
  output logic [15:0] acc_addr_o,
  output logic        acc_wr_o,
  output logic        uflow_o
);

  localparam logic [PTR_W-1:0] PTR_MASK = PTR_W'((17'd1 << SP_BITS) - 17'd1);

  sp_op_e           op;
  logic [1:0]       step;
  logic             down;
  logic [PTR_W-1:0] sp_cur;
  logic [PTR_W-1:0] sp_up1;
  logic             vld_q;
  logic             wr_q;
  logic [PTR_W-1:0] addr_q;

  sp_op_decode u_dec (
    .io_we  (io_we),
    .push_i (push_i),
    .pop_i  (pop_i),
    .call_i (call_i),
    .ret_i  (ret_i),
    .op_o   (op),
    .step_o (step),
    .down_o (down)
  );

  sp_ptr_reg #(.SP_BITS(SP_BITS)) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .io_we     (io_we),
    .io_re     (io_re),
    .io_hi_sel (io_hi_sel),
    .io_wdata  (io_wdata),
    .op_i      (op),
    .step_i    (step),
    .down_i    (down),
    .sp_o      (sp_cur),
    .io_rdata  (io_rdata)
  );

  sp_floor_guard #(.FLOOR(FLOOR)) u_guard (
    .clk     (clk),
    .rst     (rst),
    .io_we   (io_we),
    .down_i  (down),
    .step_i  (step),
    .sp_i    (sp_cur),
    .uflow_o (uflow_o)
  );

  // pre-increment read address for pop/restore
  assign sp_up1 = (sp_cur + 16'd1) & PTR_MASK;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      wr_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      vld_q <= (op != OP_NONE);
      if (op != OP_NONE) begin
        wr_q   <= down;
        addr_q <= down ? sp_cur : sp_up1;
      end
    end
  end

  assign sp_o       = sp_cur;
  assign acc_vld_o  = vld_q;
  assign acc_wr_o   = wr_q;
  assign acc_addr_o = addr_q;

endmodule

// File: rtl/sp_unit_chk.sv
module sp_unit_chk #(
  parameter int unsigned SP_BITS = 11,
  parameter int unsigned FLOOR   = 16'h0060
) (
  input logic        clk,
  input logic        rst,
  input logic        io_we,
  input logic        push_i,
  input logic        pop_i,
  input logic        call_i,
  input logic        ret_i,
  input logic [15:0] sp_o,
  input logic        acc_vld_o,
  input logic        uflow_o
);

  localparam logic [15:0] MASK = 16'((17'd1 << SP_BITS) - 17'd1);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (sp_o == 16'h0000) && !uflow_o && !acc_vld_o);

  a_r2_push_step: assert property (@(posedge clk) disable iff (rst)
    (push_i && !call_i && !ret_i && !io_we) |=> sp_o == (($past(sp_o) - 16'd1) & MASK));

  a_r3_pop_step: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !push_i && !call_i && !ret_i && !io_we) |=> sp_o == (($past(sp_o) + 16'd1) & MASK));

  a_r4_call_step: assert property (@(posedge clk) disable iff (rst)
    (call_i && !io_we) |=> sp_o == (($past(sp_o) - 16'd2) & MASK));

  a_r5_ret_step: assert property (@(posedge clk) disable iff (rst)
    (ret_i && !call_i && !io_we) |=> sp_o == (($past(sp_o) + 16'd2) & MASK));

  a_r7_write_no_access: assert property (@(posedge clk) disable iff (rst)
    io_we |=> !acc_vld_o);

  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (uflow_o && !io_we) |=> uflow_o);

  a_r10_flag_clear: assert property (@(posedge clk) disable iff (rst)
    io_we |=> !uflow_o);

  always @(posedge clk) begin
    if (!rst) begin
      a_r9_upper_zero: assert ((sp_o & ~MASK) == 16'h0000);
    end
  end

endmodule

bind sp_unit sp_unit_chk #(.SP_BITS(SP_BITS), .FLOOR(FLOOR)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .io_we     (io_we),
  .push_i    (push_i),
  .pop_i     (pop_i),
  .call_i    (call_i),
  .ret_i     (ret_i),
  .sp_o      (sp_o),
  .acc_vld_o (acc_vld_o),
  .uflow_o   (uflow_o)
);

// File: tb/sp_unit_tb_top.sv
module sp_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        io_we, io_re, io_hi_sel;
  logic [7:0]  io_wdata, io_rdata;
  logic        push_i, pop_i, call_i, ret_i;
  logic [15:0] sp_o, acc_addr_o;
  logic        acc_vld_o, acc_wr_o, uflow_o;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  sp_unit dut_i (
    .clk(clk), .rst(rst), .io_we(io_we), .io_re(io_re), .io_hi_sel(io_hi_sel),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .push_i(push_i), .pop_i(pop_i),
    .call_i(call_i), .ret_i(ret_i), .sp_o(sp_o), .acc_vld_o(acc_vld_o),
    .acc_addr_o(acc_addr_o), .acc_wr_o(acc_wr_o), .uflow_o(uflow_o)
  );

  // fields: ops {call,ret,push,pop} | expected sp | expected addr | wr | uflow
  localparam logic [37:0] VEC [10] = '{
    {4'b0010, 16'h01FF, 16'h0200, 1'b1, 1'b0},  // R2 push
    {4'b0010, 16'h01FE, 16'h01FF, 1'b1, 1'b0},  // R2 push
    {4'b0001, 16'h01FF, 16'h01FF, 1'b0, 1'b0},  // R3 pop
    {4'b1000, 16'h01FD, 16'h01FF, 1'b1, 1'b0},  // R4 save
    {4'b0100, 16'h01FF, 16'h01FE, 1'b0, 1'b0},  // R5 restore
    {4'b0001, 16'h0200, 16'h0200, 1'b0, 1'b0},  // R3 pop
    {4'b1010, 16'h01FE, 16'h0200, 1'b1, 1'b0},  // R8 save beats push
    {4'b0101, 16'h0200, 16'h01FF, 1'b0, 1'b0},  // R8 restore beats pop
    {4'b0011, 16'h01FF, 16'h0200, 1'b1, 1'b0},  // R8 push beats pop
    {4'b0110, 16'h0201, 16'h0200, 1'b0, 1'b0}   // R8 restore beats push
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [3:0] ops, input logic we, input logic hi, input logic [7:0] d);
    {call_i, ret_i, push_i, pop_i} = ops;
    io_we = we; io_hi_sel = hi; io_wdata = d;
    @(negedge clk);
    {call_i, ret_i, push_i, pop_i} = 4'b0;
    io_we = 1'b0; io_hi_sel = 1'b0; io_wdata = 8'h00;
  endtask

  task automatic load(input logic [15:0] v);
    cyc(4'b0, 1'b1, 1'b1, v[15:8]);
    cyc(4'b0, 1'b1, 1'b0, v[7:0]);
  endtask

  task automatic rd(input logic hi, output logic [7:0] v);
    io_re = 1'b1; io_hi_sel = hi;
    @(negedge clk);
    io_re = 1'b0; io_hi_sel = 1'b0;
    v = io_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    rst = 1'b1; io_we = 0; io_re = 0; io_hi_sel = 0; io_wdata = 0;
    push_i = 0; pop_i = 0; call_i = 0; ret_i = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 sp", 32'(sp_o), 32'h0);
    chk("R1 uflow", 32'(uflow_o), 32'h0);
    chk("R1 vld", 32'(acc_vld_o), 32'h0);
    chk("R1 rdata", 32'(io_rdata), 32'h0);

    load(16'h0200);
    for (int i = 0; i < 10; i++) begin
      cyc(VEC[i][37:34], 1'b0, 1'b0, 8'h00);
      chk($sformatf("R2/R3/R4/R5/R8 vec%0d sp", i), 32'(sp_o), 32'(VEC[i][33:18]));
      chk($sformatf("R2/R3/R4/R5/R8 vec%0d addr", i), 32'(acc_addr_o), 32'(VEC[i][17:2]));
      chk($sformatf("R2/R3/R4/R5/R8 vec%0d wr", i), 32'(acc_wr_o), 32'(VEC[i][1]));
      chk($sformatf("R2/R3/R4/R5/R8 vec%0d vld", i), 32'(acc_vld_o), 32'h1);
      chk($sformatf("R10 vec%0d uflow", i), 32'(uflow_o), 32'(VEC[i][0]));
    end

    // R6 half writes and read back
    cyc(4'b0, 1'b1, 1'b0, 8'h34);
    chk("R6 low write keeps high", 32'(sp_o), 32'h0234);
    cyc(4'b0, 1'b1, 1'b1, 8'h05);
    chk("R6 high write keeps low", 32'(sp_o), 32'h0534);
    rd(1'b1, rv); chk("R6 read high", 32'(rv), 32'h05);
    rd(1'b0, rv); chk("R6 read low", 32'(rv), 32'h34);

    // R9 unimplemented bits
    cyc(4'b0, 1'b1, 1'b1, 8'hFF);
    chk("R9 sp upper zero", 32'(sp_o), 32'h0734);
    rd(1'b1, rv); chk("R9 read high", 32'(rv), 32'h07);

    // R7 write beats strobe
    cyc(4'b0010, 1'b1, 1'b0, 8'h80);
    chk("R7 write wins sp", 32'(sp_o), 32'h0780);
    chk("R7 no access", 32'(acc_vld_o), 32'h0);
    cyc(4'b1001, 1'b1, 1'b1, 8'h03);
    chk("R7 write wins over save", 32'(sp_o), 32'h0380);
    chk("R7 no access save", 32'(acc_vld_o), 32'h0);

    // R11 wrap
    load(16'h07FF);
    cyc(4'b0001, 1'b0, 1'b0, 8'h00);
    chk("R11 pop wraps sp", 32'(sp_o), 32'h0000);
    chk("R11 pop wraps addr", 32'(acc_addr_o), 32'h0000);
    cyc(4'b0010, 1'b0, 1'b0, 8'h00);
    chk("R11 push wraps sp", 32'(sp_o), 32'h07FF);
    chk("R10 wrap sets uflow", 32'(uflow_o), 32'h1);

    // R10 floor boundary
    load(16'h0062);
    chk("R10 write clears", 32'(uflow_o), 32'h0);
    cyc(4'b0010, 1'b0, 1'b0, 8'h00);
    chk("R10 push to 0x61 no flag", 32'(uflow_o), 32'h0);
    cyc(4'b0010, 1'b0, 1'b0, 8'h00);
    chk("R10 push to floor flags", 32'(uflow_o), 32'h1);
    chk("R10 pointer still moves", 32'(sp_o), 32'h0060);
    cyc(4'b0001, 1'b0, 1'b0, 8'h00);
    chk("R10 sticky after pop", 32'(uflow_o), 32'h1);
    load(16'h0063);
    cyc(4'b1000, 1'b0, 1'b0, 8'h00);
    chk("R10 save to 0x61 no flag", 32'(uflow_o), 32'h0);
    load(16'h0062);
    cyc(4'b1000, 1'b0, 1'b0, 8'h00);
    chk("R10 save to floor flags", 32'(uflow_o), 32'h1);

    // R1 reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 re-reset sp", 32'(sp_o), 32'h0);
    chk("R1 re-reset uflow", 32'(uflow_o), 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule